// File: doc/BRIEF.md
# Two-Group Interrupt Controller

This block gathers up to fifteen peripheral interrupt lines and presents one request, with a 4-bit source number, to a single processor. A line that rises is latched as pending. Software can also raise sources on its own through a per-slot force register. Each source is masked per slot. A programmable level register puts every source in either a high or a low group. The processor acknowledges the number it is serving, and that clears the source. Sixteen processor slots of mask, force and extended storage are decoded. Only slot 0 takes part in driving the processor output.

Software reaches the block through a 32-bit word-access register bus with an 8-bit byte address. A read returns its data one cycle after it is issued, with `bus_ready` high in that cycle. A source whose broadcast bit is set does not go to the pending register. It sets that source in the force register of every slot.

Top module: `irqc_top`

## Requirements
- R1: After synchronous reset every register reads zero, `irq_req` is 0, `irq_num` is 0 and `bus_ready` is 0.
- R2: A 0-to-1 transition on `src_req[n]` (n = 1..15) sets pending bit n at the next clock edge. A line held high sets its bit only once, so after a clear the bit stays 0 until the line falls and rises again.
- R3: When broadcast bit n is set, a rising edge on line n sets bit n in the force register of all 16 slots and leaves pending bit n at 0.
- R4: The active set is (pending OR slot-0 force) AND slot-0 mask. `irq_req` is 1 exactly when the active set is non-zero, and it follows register changes in the same cycle they take effect.
- R5: Active sources whose level bit is 1 win over those whose level bit is 0. The low group is used only when no high-group source is active. `irq_num` gives the highest-numbered source in the winning group.
- R6: A write to a slot force register at 0x80 + 4*slot ORs in data bits 15:1 and then removes the bits given in data bits 31:17 (bit 16+n clears source n).
- R7: A write to offset 0x08 replaces slot-0 force with data bits 15:1 and ignores the upper half. A read of 0x08 returns slot-0 force.
- R8: Writing offset 0x0C removes the written bits from both pending and slot-0 force. Offsets 0x0C and 0x10 read as zero. Writes to pending (0x04) and to 0x10 change nothing.
- R9: An acknowledge with `ack_valid` = 1 and number n clears bit n of pending and of slot-0 force at the next clock edge.
- R10: Bit 0 is reserved. It reads 0 in level (0x00), pending, broadcast (0x14), masks (0x40 + 4*slot) and forces, whatever value is written, and line 0 is ignored. Only bits 15:1 of these registers are stored.
- R11: The extended registers at 0xC0 + 4*slot keep only data bits 3:0.
- R12: `bus_ready` is 1 in the cycle after each access, and read data is valid then. Offsets 0x18 to 0x3C read as zero and ignore writes. Address bits 1:0 are ignored.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_valid | input | 1 | Register access strobe, one cycle per access |
| bus_write | input | 1 | 1 for a write, 0 for a read |
| bus_addr | input | 8 | Byte address within the 256-byte window |
| bus_wdata | input | 32 | Write data |
| bus_ready | output | 1 | Access done, one cycle after the strobe |
| bus_rdata | output | 32 | Read data, valid while bus_ready is 1 |
| src_req | input | 16 | Peripheral request lines, bit 0 unused |
| ack_valid | input | 1 | Processor acknowledge strobe |
| ack_num | input | 4 | Source number being acknowledged |
| irq_req | output | 1 | Interrupt request to the processor |
| irq_num | output | 4 | Number of the winning source |

## Verification
A line edge or an acknowledge changes pending and force at the first clock edge after it is driven. A register write takes effect at the edge that accepts it. `irq_req` and `irq_num` follow those registers with no further delay, so they are due one edge after any stimulus. Read data and `bus_ready` are registered at the edge that accepts the read. The bench drives every input on a falling edge and samples on the next falling edge, which puts each sample exactly one rising edge after its cause. Checks that something stays unchanged wait several more cycles and then read the register back over the bus.

// File: rtl/irqc_pkg.sv
package irqc_pkg;
    parameter int unsigned NUM_LINES = 16;
    parameter int unsigned NUM_SLOTS = 16;
    parameter int unsigned ADDR_W    = 8;
    parameter int unsigned DATA_W    = 32;
    parameter int unsigned EXT_W     = 4;

    localparam int unsigned NUM_W  = $clog2(NUM_LINES);
    localparam int unsigned SLOT_W = $clog2(NUM_SLOTS);

    typedef logic [NUM_LINES-1:0] line_vec_t;

    // bit 0 never exists as a source
    localparam line_vec_t SRC_KEEP = ~line_vec_t'(1);

    typedef enum logic [3:0] {
        SEL_LEVEL, SEL_PEND, SEL_FALIAS, SEL_CLEAR, SEL_STATUS,
        SEL_BCAST, SEL_MASK, SEL_FORCE, SEL_EXT, SEL_NONE
    } reg_sel_e;

    typedef struct packed {
        reg_sel_e          sel;
        logic [SLOT_W-1:0] slot;
    } decode_t;

    // word index [7:2]: upper two bits pick the region, lower four the word
    function automatic decode_t decode_addr(logic [ADDR_W-1:0] a);
        decode_t d;
        d.slot = a[2 +: SLOT_W];
        case (a[7:6])
            2'b00: begin
                case (a[5:2])
                    4'd0:    d.sel = SEL_LEVEL;
                    4'd1:    d.sel = SEL_PEND;
                    4'd2:    d.sel = SEL_FALIAS;
                    4'd3:    d.sel = SEL_CLEAR;
                    4'd4:    d.sel = SEL_STATUS;
                    4'd5:    d.sel = SEL_BCAST;
                    default: d.sel = SEL_NONE;
                endcase
            end
            2'b01:   d.sel = SEL_MASK;
            2'b10:   d.sel = SEL_FORCE;
            default: d.sel = SEL_EXT;
        endcase
        return d;
    endfunction

    // index of the highest set bit, 0 when empty
    function automatic logic [NUM_W-1:0] top_index(line_vec_t v);
        logic [NUM_W-1:0] idx;
        idx = '0;
        for (int i = 0; i < NUM_LINES; i++) begin
            if (v[i]) idx = NUM_W'(i);
        end
        return idx;
    endfunction
endpackage

// File: rtl/irqc_edge.sv
module irqc_edge
    import irqc_pkg::*;
(
    input  logic      clk,
    input  logic      rst,
    input  line_vec_t src_req,
    output line_vec_t rise
);
    line_vec_t prev_q;

    always_ff @(posedge clk) begin
        if (rst) prev_q <= '0;
        else     prev_q <= src_req;
    end

    assign rise = src_req & ~prev_q & SRC_KEEP;

    // R2: a line held high for two edges produces no new rise
    assert_held_no_rise_R2: assert property (@(posedge clk) disable iff (rst)
        $past(src_req) == src_req |-> (rise & $past(src_req)) == '0);
endmodule

// File: rtl/irqc_regs.sv
module irqc_regs
    import irqc_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              bus_valid,
    input  logic              bus_write,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [DATA_W-1:0] bus_wdata,
    output logic              bus_ready,
    output logic [DATA_W-1:0] bus_rdata,
    input  line_vec_t         rise,
    input  logic              ack_valid,
    input  logic [NUM_W-1:0]  ack_num,
    output line_vec_t         level_o,
    output line_vec_t         pending_o,
    output line_vec_t         force0_o,
    output line_vec_t         mask0_o
);
    decode_t   dec;
    logic      wr, rd;
    line_vec_t data_lo, data_hi;
    line_vec_t ack_vec, clr_vec;
    line_vec_t pend_set, bcast_set;

    line_vec_t              level_q, pending_q, bcast_q;
    line_vec_t              force_q [NUM_SLOTS];
    line_vec_t              force_nx[NUM_SLOTS];
    line_vec_t              mask_q  [NUM_SLOTS];
    logic [EXT_W-1:0]       ext_q   [NUM_SLOTS];
    logic [DATA_W-1:0]      rd_val;
    logic [1:0]             unused_addr;

    assign unused_addr = bus_addr[1:0];
    assign dec     = decode_addr(bus_addr);
    assign wr      = bus_valid &  bus_write;
    assign rd      = bus_valid & ~bus_write;
    assign data_lo = bus_wdata[0 +: NUM_LINES] & SRC_KEEP;
    assign data_hi = bus_wdata[NUM_LINES +: NUM_LINES] & SRC_KEEP;

    assign ack_vec   = ack_valid ? (line_vec_t'(1) << ack_num) : '0;
    assign clr_vec   = ack_vec | ((wr && dec.sel == SEL_CLEAR) ? data_lo : '0);
    assign bcast_set = rise & bcast_q;
    assign pend_set  = rise & ~bcast_q;

    // next force value per slot; a new request in the same cycle wins over clears
    always_comb begin
        for (int s = 0; s < NUM_SLOTS; s++) begin
            force_nx[s] = force_q[s];
            if (wr && dec.sel == SEL_FORCE && int'(dec.slot) == s)
                force_nx[s] = (force_q[s] | data_lo) & ~data_hi;
        end
        if (wr && dec.sel == SEL_FALIAS) force_nx[0] = data_lo;
        force_nx[0] = force_nx[0] & ~clr_vec;
        for (int s = 0; s < NUM_SLOTS; s++) force_nx[s] = force_nx[s] | bcast_set;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            level_q   <= '0;
            pending_q <= '0;
            bcast_q   <= '0;
            for (int s = 0; s < NUM_SLOTS; s++) begin
                force_q[s] <= '0;
                mask_q[s]  <= '0;
                ext_q[s]   <= '0;
            end
        end else begin
            pending_q <= (pending_q & ~clr_vec) | pend_set;
            if (wr && dec.sel == SEL_LEVEL) level_q <= data_lo;
            if (wr && dec.sel == SEL_BCAST) bcast_q <= data_lo;
            for (int s = 0; s < NUM_SLOTS; s++) begin
                force_q[s] <= force_nx[s];
                if (wr && dec.sel == SEL_MASK && int'(dec.slot) == s)
                    mask_q[s] <= data_lo;
                if (wr && dec.sel == SEL_EXT && int'(dec.slot) == s)
                    ext_q[s] <= bus_wdata[EXT_W-1:0];
            end
        end
    end

    always_comb begin
        case (dec.sel)
            SEL_LEVEL:  rd_val = DATA_W'(level_q);
            SEL_PEND:   rd_val = DATA_W'(pending_q);
            SEL_FALIAS: rd_val = DATA_W'(force_q[0]);
            SEL_BCAST:  rd_val = DATA_W'(bcast_q);
            SEL_MASK:   rd_val = DATA_W'(mask_q[dec.slot]);
            SEL_FORCE:  rd_val = DATA_W'(force_q[dec.slot]);
            SEL_EXT:    rd_val = DATA_W'(ext_q[dec.slot]);
            default:    rd_val = '0;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            bus_ready <= 1'b0;
            bus_rdata <= '0;
        end else begin
            bus_ready <= bus_valid;
            bus_rdata <= rd ? rd_val : '0;
        end
    end

    assign level_o   = level_q;
    assign pending_o = pending_q;
    assign force0_o  = force_q[0];
    assign mask0_o   = mask_q[0];

    // R12: every access is answered on the next cycle
    assert_ready_next_R12: assert property (@(posedge clk) disable iff (rst)
        bus_valid |=> bus_ready);

    // R10: reserved bit never held
    assert_bit0_zero_R10: assert property (@(posedge clk) disable iff (rst)
        !pending_q[0] && !force_q[0][0] && !level_q[0] && !mask_q[0][0]);

    // R9: acknowledged source is gone unless it re-fires in that cycle
    assert_ack_clears_R9: assert property (@(posedge clk) disable iff (rst)
        ack_valid && !rise[ack_num] |=> !pending_q[$past(ack_num)] && !force_q[0][$past(ack_num)]);

    // R8: clear and status read as zero
    assert_clear_reads_zero_R8: assert property (@(posedge clk) disable iff (rst)
        rd && (dec.sel == SEL_CLEAR || dec.sel == SEL_STATUS) |=> bus_rdata == '0);

    // R8: a pending write with no other cause leaves pending alone
    assert_pend_readonly_R8: assert property (@(posedge clk) disable iff (rst)
        wr && dec.sel == SEL_PEND && rise == '0 && !ack_valid |=> $stable(pending_q));
endmodule

// File: rtl/irqc_prio.sv
module irqc_prio
    import irqc_pkg::*;
(
    input  line_vec_t        pending,
    input  line_vec_t        force0,
    input  line_vec_t        mask0,
    input  line_vec_t        level,
    output logic             irq_req,
    output logic [NUM_W-1:0] irq_num
);
    line_vec_t active, hi_grp, lo_grp, winner;

    assign active  = (pending | force0) & mask0;
    assign hi_grp  = active & level;
    assign lo_grp  = active & ~level;
    assign winner  = (hi_grp != '0) ? hi_grp : lo_grp;
    assign irq_req = active != '0;
    assign irq_num = top_index(winner);
endmodule

// File: rtl/irqc_top.sv
module irqc_top
    import irqc_pkg::*;
(
    input  logic        clk,
    input  logic        rst,
    input  logic        bus_valid,
    input  logic        bus_write,
    input  logic [7:0]  bus_addr,
    input  logic [31:0] bus_wdata,
    output logic        bus_ready,
    output logic [31:0] bus_rdata,
    input  logic [15:0] src_req,
    input  logic        ack_valid,
    input  logic [3:0]  ack_num,
    output logic        irq_req,
    output logic [3:0]  irq_num
);
    line_vec_t rise, level, pending, force0, mask0;

    irqc_edge u_edge (
        .clk     (clk),
        .rst     (rst),
        .src_req (src_req),
        .rise    (rise)
    );

    irqc_regs u_regs (
        .clk       (clk),
        .rst       (rst),
        .bus_valid (bus_valid),
        .bus_write (bus_write),
        .bus_addr  (bus_addr),
        .bus_wdata (bus_wdata),
        .bus_ready (bus_ready),
        .bus_rdata (bus_rdata),
        .rise      (rise),
        .ack_valid (ack_valid),
        .ack_num   (ack_num),
        .level_o   (level),
        .pending_o (pending),
        .force0_o  (force0),
        .mask0_o   (mask0)
    );

    irqc_prio u_prio (
        .pending (pending),
        .force0  (force0),
        .mask0   (mask0),
        .level   (level),
        .irq_req (irq_req),
        .irq_num (irq_num)
    );

    // R4: the reported source is unmasked and raised
    assert_req_source_valid_R4: assert property (@(posedge clk) disable iff (rst)
        irq_req |-> mask0[irq_num] && (pending[irq_num] || force0[irq_num]));

    // R5: a low-group winner means no high-group source is active
    assert_high_first_R5: assert property (@(posedge clk) disable iff (rst)
        irq_req && !level[irq_num] |-> ((pending | force0) & mask0 & level) == '0);
endmodule

// File: tb/irqc_top_tb.sv
module irqc_top_tb;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        bus_valid = 1'b0;
    logic        bus_write = 1'b0;
    logic [7:0]  bus_addr = '0;
    logic [31:0] bus_wdata = '0;
    logic        bus_ready;
    logic [31:0] bus_rdata;
    logic [15:0] src_req = '0;
    logic        ack_valid = 1'b0;
    logic [3:0]  ack_num = '0;
    logic        irq_req;
    logic [3:0]  irq_num;

    int checks = 0;
    int failures = 0;
    logic done = 1'b0;

    always #4 clk = ~clk;

    irqc_top u_dut (
        .clk(clk), .rst(rst),
        .bus_valid(bus_valid), .bus_write(bus_write), .bus_addr(bus_addr),
        .bus_wdata(bus_wdata), .bus_ready(bus_ready), .bus_rdata(bus_rdata),
        .src_req(src_req), .ack_valid(ack_valid), .ack_num(ack_num),
        .irq_req(irq_req), .irq_num(irq_num)
    );

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s actual=0x%08h expected=0x%08h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [7:0] a, input logic [31:0] d);
        @(negedge clk);
        bus_valid = 1'b1; bus_write = 1'b1; bus_addr = a; bus_wdata = d;
        @(negedge clk);
        bus_valid = 1'b0; bus_write = 1'b0;
    endtask

    task automatic rd(input logic [7:0] a, output logic [31:0] d, output logic rdy);
        @(negedge clk);
        bus_valid = 1'b1; bus_write = 1'b0; bus_addr = a;
        @(negedge clk);
        bus_valid = 1'b0;
        d = bus_rdata; rdy = bus_ready;
    endtask

    task automatic rd_check(input string req, input logic [7:0] a, input logic [31:0] exp);
        logic [31:0] d;
        logic rdy;
        rd(a, d, rdy);
        check(req, d, exp);
    endtask

    task automatic set_src(input logic [15:0] v);
        @(negedge clk);
        src_req = v;
    endtask

    task automatic ack(input logic [3:0] n);
        @(negedge clk);
        ack_valid = 1'b1; ack_num = n;
        @(negedge clk);
        ack_valid = 1'b0;
    endtask

    // fields: req[76:73] wr[72] addr[71:64] data[63:32] expected read[31:0]
    localparam int NVEC = 16;
    localparam logic [76:0] VEC [NVEC] = '{
        {4'd1,  1'b0, 8'h00, 32'h0,          32'h0},        // R1 level after reset
        {4'd10, 1'b1, 8'h40, 32'hFFFF_FFFF,  32'h0},        // R10 mask slot 0
        {4'd10, 1'b0, 8'h40, 32'h0,          32'h0000_FFFE},
        {4'd10, 1'b1, 8'h88, 32'h0000_00F3,  32'h0},        // R10 force slot 2
        {4'd10, 1'b0, 8'h88, 32'h0,          32'h0000_00F2},
        {4'd6,  1'b1, 8'h88, 32'h0030_0100,  32'h0},        // R6 set 0x100 clear 0x30
        {4'd6,  1'b0, 8'h88, 32'h0,          32'h0000_01C2},
        {4'd11, 1'b1, 8'hC4, 32'hFFFF_FFFF,  32'h0},        // R11 extended slot 1
        {4'd11, 1'b0, 8'hC4, 32'h0,          32'h0000_000F},
        {4'd12, 1'b1, 8'h20, 32'h1234_5678,  32'h0},        // R12 unmapped
        {4'd12, 1'b0, 8'h20, 32'h0,          32'h0},
        {4'd8,  1'b1, 8'h04, 32'h0000_FFFF,  32'h0},        // R8 pending read-only
        {4'd8,  1'b0, 8'h04, 32'h0,          32'h0},
        {4'd10, 1'b1, 8'h17, 32'h0000_FFFF,  32'h0},        // R10 broadcast, low address bits ignored (R12)
        {4'd10, 1'b0, 8'h14, 32'h0,          32'h0000_FFFE},
        {4'd10, 1'b1, 8'h14, 32'h0,          32'h0}         // restore broadcast
    };

    initial begin
        logic [31:0] d;
        logic rdy;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        // R1 reset state
        check("R1 irq_req", {31'b0, irq_req}, 32'h0);
        check("R1 irq_num", {28'b0, irq_num}, 32'h0);
        check("R1 bus_ready", {31'b0, bus_ready}, 32'h0);

        for (int i = 0; i < NVEC; i++) begin
            if (VEC[i][72]) wr(VEC[i][71:64], VEC[i][63:32]);
            else begin
                rd(VEC[i][71:64], d, rdy);
                check($sformatf("R%0d vector %0d", VEC[i][76:73], i), d, VEC[i][31:0]);
                check("R12 ready", {31'b0, rdy}, 32'h1);
            end
        end
        rd_check("R8 clear reads zero", 8'h0C, 32'h0);
        wr(8'h10, 32'hFFFF_FFFF);
        rd_check("R8 status reads zero", 8'h10, 32'h0);
        rd_check("R1 force slot 0", 8'h80, 32'h0);

        // R2/R4 edge capture, mask open
        wr(8'h40, 32'h0000_FFFE);
        set_src(16'h0020);
        @(negedge clk);
        check("R4 irq_req", {31'b0, irq_req}, 32'h1);
        check("R2 irq_num", {28'b0, irq_num}, 32'h5);
        rd_check("R2 pending", 8'h04, 32'h0000_0020);
        wr(8'h0C, 32'h0000_0020);
        check("R8 clear drops request", {31'b0, irq_req}, 32'h0);
        repeat (3) @(negedge clk);
        rd_check("R2 held line no retrigger", 8'h04, 32'h0);
        set_src(16'h0000);
        set_src(16'h0020);
        @(negedge clk);
        rd_check("R2 second edge", 8'h04, 32'h0000_0020);
        ack(4'd5);
        check("R9 ack drops request", {31'b0, irq_req}, 32'h0);
        rd_check("R9 ack clears pending", 8'h04, 32'h0);
        set_src(16'h0001);
        set_src(16'h0000);
        rd_check("R10 line 0 ignored", 8'h04, 32'h0);

        // R5 priority
        set_src(16'h0208);
        @(negedge clk);
        check("R5 low group highest", {28'b0, irq_num}, 32'h9);
        wr(8'h00, 32'h0000_0008);
        check("R5 high group wins", {28'b0, irq_num}, 32'h3);
        wr(8'h00, 32'h0000_0208);
        check("R5 both high highest", {28'b0, irq_num}, 32'h9);
        wr(8'h40, 32'h0000_0008);
        check("R4 mask hides 9", {28'b0, irq_num}, 32'h3);
        wr(8'h40, 32'h0);
        check("R4 all masked", {31'b0, irq_req}, 32'h0);
        wr(8'h0C, 32'h0000_0208);
        wr(8'h00, 32'h0);
        set_src(16'h0000);
        wr(8'h40, 32'h0000_FFFE);

        // R7 alias replaces force slot 0
        wr(8'h80, 32'h0000_0100);
        wr(8'h08, 32'h0001_0013);
        rd_check("R7 alias via slot 0", 8'h80, 32'h0000_0012);
        rd_check("R7 alias read", 8'h08, 32'h0000_0012);
        check("R4 force drives irq", {28'b0, irq_num}, 32'h4);
        wr(8'h0C, 32'h0000_0010);
        check("R8 clear hits force", {28'b0, irq_num}, 32'h1);
        ack(4'd1);
        check("R9 ack hits force", {31'b0, irq_req}, 32'h0);

        // R3 broadcast
        wr(8'h14, 32'h0000_0080);
        set_src(16'h0080);
        @(negedge clk);
        check("R3 irq_num", {28'b0, irq_num}, 32'h7);
        rd_check("R3 pending untouched", 8'h04, 32'h0);
        rd_check("R3 slot 0 force", 8'h80, 32'h0000_0080);
        rd_check("R3 slot 15 force", 8'hBC, 32'h0000_0080);
        set_src(16'h0000);

        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        done = 1'b1;
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            failures++;
            $display("FAIL watchdog actual=running expected=finished");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end
endmodule